// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

This core is a compact stack machine whose instructions name only an operation and never a register. The arithmetic and logic operations always read the top-of-stack register (T) and the register just beneath it (S). The deeper data stack sits in a small circular register file inside the core, so operations on stack values never touch data memory. Each instruction-memory word carries four 5-bit opcodes. They run one after another before the next word is fetched, so one memory read serves several stack operations.

The core computes every candidate result for T at the same time, in the cycle the opcode is decoded. Decode only chooses which result is written back, so there is no separate phase for routing operands. Literal values and jump, branch and call targets live in the full instruction word that follows the packed word. The program counter steps over that word. A return stack of eight entries holds the call return addresses. A simple data-memory port, read combinationally and written in one cycle, serves the fetch and store opcodes. T, S and the PC are brought out for observation.

Top module: `zop_core`

## Requirements
- R1: While reset is asserted, and after its release until the first operation executes, T, S and the PC read zero. Reset also clears both stack pointers and all stack entries. Release passes through a two-stage synchronizer, so the core leaves its fetch state on the third rising edge after the reset input goes high.
- R2: Opcodes are 5 bits and are packed into a 20-bit word. The slot in bits 19:15 runs first and the slot in bits 4:0 runs last. The codes are: nop 0, add 1, xor 2, and 3, not 4, dup 5, drop 6, swap 7, over 8, literal 9, fetch 10, store 11, jump 12, jump-if-zero 13, call 14, return 15. Codes 16 to 31 behave as nop.
- R3: A word costs one address cycle and one load cycle, and the PC increments on the load edge. Each opcode takes one cycle. Literal, jump, jump-if-zero and call take one extra cycle, during which the following word is read.
- R4: add, xor and and write f(T,S) into T and pop S from the stack file. not inverts T and leaves S unchanged.
- R5: dup gives (a -- a a). drop gives (a b -- a). swap gives (a b -- b a). over gives (a b -- a b a).
- R6: A literal pushes the low 16 bits of the following word. The PC skips that word, and the remaining slots still run.
- R7: fetch replaces T with the data read at address T. store writes S to address T, raising the write strobe for exactly its execution cycle, and then pops both values.
- R8: A jump loads the PC from the low 8 bits of the following word and discards the remaining slots.
- R9: jump-if-zero always pops T. It jumps as a jump does when the popped T was zero. Otherwise it skips the target word and continues with the next slot.
- R10: call pushes the address just past its target word onto the return stack, jumps, and discards the remaining slots. return pops that address into the PC and discards the remaining slots.
- R11: The data stack below S holds 8 entries in a circular buffer. Pushing past 8 silently overwrites the oldest entry, and popping past the bottom wraps.
- R12: The return stack holds 8 entries in a circular buffer that wraps silently in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Instruction-memory read address |
| imem_rdata | input | 20 | Instruction-memory data, one cycle after the address |
| dmem_addr | output | 16 | Data-memory address (equals T) |
| dmem_wdata | output | 16 | Data-memory write value (equals S) |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_rdata | input | 16 | Data-memory combinational read data |
| dbg_t | output | 16 | Top-of-stack register |
| dbg_s | output | 16 | Second-of-stack register |
| dbg_pc | output | 8 | Program counter |

## Verification
Stack wrap is the hardest condition to reach from the ports, and return-stack wrap is harder still, because the overwritten entries are visible only after enough pops. The stimulus builds a long run of packed literals, which pushes the data stack past eight and then drains it with adds. It also builds a chain of nine nested calls, generated in a loop, whose unwinding must return through an overwritten slot. A behavioural interpreter in the bench predicts T, S, PC and the write strobe for every cycle, so any divergence shows up in the cycle where it first occurs.

// File: rtl/zop_pkg.sv
package zop_pkg;
  localparam int OPW   = 5;
  localparam int SLOTS = 4;
  localparam int IW    = OPW * SLOTS;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_XOR   = 5'd2,
    OP_AND   = 5'd3,
    OP_NOT   = 5'd4,
    OP_DUP   = 5'd5,
    OP_DROP  = 5'd6,
    OP_SWAP  = 5'd7,
    OP_OVER  = 5'd8,
    OP_LIT   = 5'd9,
    OP_FETCH = 5'd10,
    OP_STORE = 5'd11,
    OP_JMP   = 5'd12,
    OP_JZ    = 5'd13,
    OP_CALL  = 5'd14,
    OP_RET   = 5'd15
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_LOAD  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_ARG   = 2'd3
  } seq_e;
endpackage

// File: rtl/zop_alu.sv
module zop_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] s_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] xor_o,
  output logic [DW-1:0] and_o,
  output logic [DW-1:0] inv_o
);
  // Every candidate is formed in parallel; the sequencer only picks one.
  assign sum_o = t_i + s_i;
  assign xor_o = t_i ^ s_i;
  assign and_o = t_i & s_i;
  assign inv_o = ~t_i;
endmodule

// File: rtl/zop_lifo.sv
module zop_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         pop2_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] next_o
);
  // DEPTH must be a power of two so pointer arithmetic wraps the ring.
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q, ptr_d, wptr;
  logic [W-1:0]  mem_q [DEPTH];

  assign wptr = ptr_q + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (push_i)      ptr_d = ptr_q + PW'(1);
    else if (pop_i)  ptr_d = ptr_q - PW'(1);
    else if (pop2_i) ptr_d = ptr_q - PW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (push_i) begin
      mem_q[wptr] <= wdata_i;
    end
  end

  assign top_o  = mem_q[ptr_q];
  assign next_o = mem_q[ptr_q - 1'b1];

  // R11
  single_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push_i, pop_i, pop2_i}) <= 1);

  // R11
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(wdata_i));
endmodule

// File: rtl/zop_core.sv
module zop_core
  import zop_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int DDEPTH = 8,
  parameter int RDEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [DW-1:0] dmem_rdata,
  output logic [DW-1:0] dbg_t,
  output logic [DW-1:0] dbg_s,
  output logic [AW-1:0] dbg_pc
);
  localparam int SW = $clog2(SLOTS);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  seq_e            state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic [IW-1:0]   ir_q, ir_d;
  logic [SW-1:0]   slot_q, slot_d;
  logic [DW-1:0]   t_q, t_d, s_q, s_d;
  logic            ir_en;

  logic [OPW-1:0]  op;
  logic            last_slot, adv;
  logic [DW-1:0]   sum_w, xor_w, and_w, inv_w;
  logic            dpush, dpop, dpop2, rpush, rpop;
  logic [DW-1:0]   dtop, dnext;
  logic [AW-1:0]   rtop, rnext_unused, ret_addr;

  assign op        = OPW'(ir_q >> (OPW * (SLOTS - 1 - int'(slot_q))));
  assign last_slot = (slot_q == SW'(SLOTS - 1));
  assign ret_addr  = pc_q + 1'b1;

  zop_alu #(.DW(DW)) u_alu (
    .t_i(t_q), .s_i(s_q),
    .sum_o(sum_w), .xor_o(xor_w), .and_o(and_w), .inv_o(inv_w)
  );

  zop_lifo #(.W(DW), .DEPTH(DDEPTH)) u_dstack (
    .clk(clk), .rst_n(rst_core_n),
    .push_i(dpush), .pop_i(dpop), .pop2_i(dpop2),
    .wdata_i(s_q), .top_o(dtop), .next_o(dnext)
  );

  zop_lifo #(.W(AW), .DEPTH(RDEPTH)) u_rstack (
    .clk(clk), .rst_n(rst_core_n),
    .push_i(rpush), .pop_i(rpop), .pop2_i(1'b0),
    .wdata_i(ret_addr), .top_o(rtop), .next_o(rnext_unused)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    ir_en   = 1'b0;
    slot_d  = slot_q;
    t_d     = t_q;
    s_d     = s_q;
    dpush   = 1'b0;
    dpop    = 1'b0;
    dpop2   = 1'b0;
    rpush   = 1'b0;
    rpop    = 1'b0;
    dmem_we = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_LOAD;
      ST_LOAD: begin
        ir_en   = 1'b1;
        ir_d    = imem_rdata;
        pc_d    = pc_q + 1'b1;
        slot_d  = '0;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        case (op)
          OP_ADD:   begin t_d = sum_w; s_d = dtop; dpop = 1'b1; adv = 1'b1; end
          OP_XOR:   begin t_d = xor_w; s_d = dtop; dpop = 1'b1; adv = 1'b1; end
          OP_AND:   begin t_d = and_w; s_d = dtop; dpop = 1'b1; adv = 1'b1; end
          OP_NOT:   begin t_d = inv_w; adv = 1'b1; end
          OP_DUP:   begin s_d = t_q; dpush = 1'b1; adv = 1'b1; end
          OP_DROP:  begin t_d = s_q; s_d = dtop; dpop = 1'b1; adv = 1'b1; end
          OP_SWAP:  begin t_d = s_q; s_d = t_q; adv = 1'b1; end
          OP_OVER:  begin t_d = s_q; s_d = t_q; dpush = 1'b1; adv = 1'b1; end
          OP_FETCH: begin t_d = dmem_rdata; adv = 1'b1; end
          OP_STORE: begin
            dmem_we = 1'b1;
            t_d = dtop; s_d = dnext; dpop2 = 1'b1; adv = 1'b1;
          end
          OP_RET:   begin pc_d = rtop; rpop = 1'b1; state_d = ST_FETCH; end
          OP_LIT, OP_JMP, OP_JZ, OP_CALL: state_d = ST_ARG;
          default:  adv = 1'b1;
        endcase
      end
      ST_ARG: begin
        case (op)
          OP_LIT: begin
            s_d = t_q; t_d = imem_rdata[DW-1:0]; dpush = 1'b1;
            pc_d = pc_q + 1'b1; adv = 1'b1;
          end
          OP_JMP: begin pc_d = imem_rdata[AW-1:0]; state_d = ST_FETCH; end
          OP_JZ: begin
            t_d = s_q; s_d = dtop; dpop = 1'b1;
            if (t_q == '0) begin
              pc_d = imem_rdata[AW-1:0]; state_d = ST_FETCH;
            end else begin
              pc_d = pc_q + 1'b1; adv = 1'b1;
            end
          end
          OP_CALL: begin
            rpush = 1'b1; pc_d = imem_rdata[AW-1:0]; state_d = ST_FETCH;
          end
          default: state_d = ST_FETCH;
        endcase
      end
      default: state_d = ST_FETCH;
    endcase
    if (adv) begin
      if (last_slot) state_d = ST_FETCH;
      else begin
        slot_d  = slot_q + 1'b1;
        state_d = ST_EXEC;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      slot_q  <= '0;
      t_q     <= '0;
      s_q     <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      slot_q  <= slot_d;
      t_q     <= t_d;
      s_q     <= s_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  ir_q <= '0;
    else if (ir_en)   ir_q <= ir_d;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = t_q;
  assign dmem_wdata = s_q;
  assign dbg_t      = t_q;
  assign dbg_s      = s_q;
  assign dbg_pc     = pc_q;

  // R3
  load_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    state_q == ST_LOAD |=> (state_q == ST_EXEC && slot_q == '0 &&
                            pc_q == $past(pc_q) + 1'b1));

  // R3
  exec_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_EXEC && op != OP_RET) |=> $stable(pc_q));

  // R4
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_EXEC && op == OP_ADD) |=> t_q == $past(t_q) + $past(s_q));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_ARG && op == OP_JMP) |=>
      (state_q == ST_FETCH && pc_q == $past(imem_rdata[AW-1:0])));

  // R7
  store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    dmem_we |=> !dmem_we);
endmodule

// File: tb/zop_core_tb.sv
module zop_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOP = 0, ADD = 1, XOR = 2, AND = 3, NOT = 4, DUP = 5,
                 DROP = 6, SWAP = 7, OVER = 8, LIT = 9, FET = 10, STO = 11,
                 JMP = 12, JZ = 13, CALL = 14, RET = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [19:0] imem_rdata;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata, dbg_t, dbg_s;
  logic        dmem_we;
  logic [7:0]  dbg_pc;

  logic [19:0] imem [256];
  logic [15:0] dmem [16];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zop_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata),
    .dbg_t(dbg_t), .dbg_s(dbg_s), .dbg_pc(dbg_pc)
  );

  always @(posedge clk) imem_rdata <= imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr[3:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[3:0]] <= dmem_wdata;

  // behavioural reference model
  int m_t, m_s, m_pc, m_ir, m_slot, m_st, m_dead, m_dp, m_rp;
  int m_ds [8];
  int m_rs [8];
  int m_dm [16];

  function automatic logic [19:0] w4(int a, int b, int c, int d);
    return {5'(a), 5'(b), 5'(c), 5'(d)};
  endfunction

  function automatic int cur_op();
    return (m_ir >> (15 - 5*m_slot)) & 31;
  endfunction

  task automatic m_push(int v);
    m_dp = (m_dp + 1) & 7; m_ds[m_dp] = m_s; m_s = m_t; m_t = v & 16'hFFFF;
  endtask

  task automatic m_pop(int v);
    m_t = v & 16'hFFFF; m_s = m_ds[m_dp]; m_dp = (m_dp - 1) & 7;
  endtask

  task automatic m_adv();
    m_st = 2;
    if (m_slot == 3) m_st = 0; else m_slot++;
  endtask

  task automatic m_reset();
    m_t = 0; m_s = 0; m_pc = 0; m_ir = 0; m_slot = 0; m_st = 0; m_dead = 2;
    m_dp = 0; m_rp = 0;
    for (int i = 0; i < 8; i++) begin m_ds[i] = 0; m_rs[i] = 0; end
    for (int i = 0; i < 16; i++) m_dm[i] = 0;
  endtask

  task automatic m_step();
    int op, arg, a, b;
    if (m_dead > 0) begin m_dead--; return; end
    case (m_st)
      0: m_st = 1;
      1: begin m_ir = int'(imem[m_pc]); m_pc = (m_pc + 1) & 255; m_slot = 0; m_st = 2; end
      2: begin
        op = cur_op();
        case (op)
          ADD:  begin m_pop(m_t + m_s); m_adv(); end
          XOR:  begin m_pop(m_t ^ m_s); m_adv(); end
          AND:  begin m_pop(m_t & m_s); m_adv(); end
          NOT:  begin m_t = (~m_t) & 16'hFFFF; m_adv(); end
          DUP:  begin m_push(m_t); m_adv(); end
          DROP: begin m_pop(m_s); m_adv(); end
          SWAP: begin a = m_t; m_t = m_s; m_s = a; m_adv(); end
          OVER: begin m_push(m_s); m_adv(); end
          FET:  begin m_t = m_dm[m_t & 15]; m_adv(); end
          STO:  begin
            m_dm[m_t & 15] = m_s;
            a = m_ds[m_dp]; b = m_ds[(m_dp - 1) & 7];
            m_t = a; m_s = b; m_dp = (m_dp - 2) & 7; m_adv();
          end
          RET:  begin m_pc = m_rs[m_rp]; m_rp = (m_rp - 1) & 7; m_st = 0; end
          LIT, JMP, JZ, CALL: m_st = 3;
          default: m_adv();
        endcase
      end
      default: begin
        op = cur_op(); arg = int'(imem[m_pc]);
        case (op)
          LIT:  begin m_push(arg); m_pc = (m_pc + 1) & 255; m_adv(); end
          JMP:  begin m_pc = arg & 255; m_st = 0; end
          JZ:   begin
            a = m_t; m_pop(m_s);
            if (a == 0) begin m_pc = arg & 255; m_st = 0; end
            else begin m_pc = (m_pc + 1) & 255; m_adv(); end
          end
          CALL: begin
            m_rp = (m_rp + 1) & 7; m_rs[m_rp] = (m_pc + 1) & 255;
            m_pc = arg & 255; m_st = 0;
          end
          default: m_st = 0;
        endcase
      end
    endcase
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    int exp_we;
    exp_we = (m_dead == 0 && m_st == 2 && cur_op() == STO) ? 1 : 0;
    check(req, "T",  int'(dbg_t),  m_t);
    check(req, "S",  int'(dbg_s),  m_s);
    check(req, "PC", int'(dbg_pc), m_pc);
    check(req, "WE", int'(dmem_we), exp_we);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) imem[i] = w4(NOP, NOP, NOP, NOP);
    for (int i = 0; i < 16; i++) dmem[i] = '0;
  endtask

  task automatic run(string req, int ncyc);
    m_reset();
    @(negedge clk);
    // R1: reset state visible while reset is held
    check("R1", "reset T",  int'(dbg_t), 0);
    check("R1", "reset S",  int'(dbg_s), 0);
    check("R1", "reset PC", int'(dbg_pc), 0);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      @(negedge clk);
      m_step();
      compare(req);
    end
    rst_n = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R4 R5 R2: arithmetic, stack shuffles, unused code acts as nop
    clear_mem();
    imem[0] = w4(LIT, LIT, ADD, DUP);
    imem[1] = 20'd5;
    imem[2] = 20'd7;
    imem[3] = w4(OVER, SWAP, XOR, NOT);
    imem[4] = w4(DROP, LIT, AND, 31);
    imem[5] = 20'h0F0F;
    imem[6] = w4(22, DUP, JMP, NOP);
    imem[7] = 20'd0;
    run("R4", 90);

    // R6 R7: literal then store, fetch back
    clear_mem();
    imem[0] = w4(LIT, LIT, STO, LIT);
    imem[1] = 20'hBEEF;
    imem[2] = 20'd3;
    imem[3] = 20'd3;
    imem[4] = w4(FET, DUP, ADD, JMP);
    imem[5] = 20'd0;
    run("R7", 80);

    // R9: branch taken and not taken
    clear_mem();
    imem[0]  = w4(LIT, JZ, LIT, NOP);
    imem[1]  = 20'd0;
    imem[2]  = 20'd10;
    imem[10] = w4(LIT, JZ, LIT, JMP);
    imem[11] = 20'd4;
    imem[12] = 20'd20;
    imem[13] = 20'd9;
    imem[14] = 20'd0;
    run("R9", 80);

    // R10 R8: call, return, jump, discarded slots
    clear_mem();
    imem[0]  = w4(LIT, CALL, ADD, ADD);
    imem[1]  = 20'd2;
    imem[2]  = 20'd30;
    imem[3]  = w4(DUP, ADD, JMP, NOP);
    imem[4]  = 20'd0;
    imem[30] = w4(LIT, RET, ADD, ADD);
    imem[31] = 20'd40;
    run("R10", 90);

    // R11: push twelve literals past eight entries, then drain
    clear_mem();
    for (int g = 0; g < 3; g++) begin
      imem[5*g] = w4(LIT, LIT, LIT, LIT);
      for (int k = 0; k < 4; k++) imem[5*g + 1 + k] = 20'(1 + 4*g + k);
    end
    imem[15] = w4(ADD, ADD, ADD, ADD);
    imem[16] = w4(ADD, ADD, ADD, ADD);
    imem[17] = w4(ADD, ADD, DROP, JMP);
    imem[18] = 20'd0;
    run("R11", 130);

    // R12: nine nested calls overrun the return stack
    clear_mem();
    imem[0] = w4(CALL, NOP, NOP, NOP);
    imem[1] = 20'd40;
    imem[2] = w4(JMP, NOP, NOP, NOP);
    imem[3] = 20'd2;
    for (int k = 0; k < 9; k++) begin
      if (k < 8) begin
        imem[40 + 3*k]     = w4(CALL, NOP, NOP, NOP);
        imem[40 + 3*k + 1] = 20'(40 + 3*(k + 1));
        imem[40 + 3*k + 2] = w4(RET, NOP, NOP, NOP);
      end else begin
        imem[40 + 3*k] = w4(RET, NOP, NOP, NOP);
      end
    end
    run("R12", 160);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule